// File: doc/BRIEF.md
# Two-Port Shared Word Memory with Collision Arbitration

This block is a synchronous word memory with two fully independent access ports, called left and right. Each port has its own enable, write strobe, read strobe, address and write data, so either side may read or write any word at any time. The block detects a collision when both ports are enabled on the same word. In that case it chooses one owner and raises a busy flag towards the other port, and the losing port's write is dropped.

A role strap sets the arbitration mode. In master role the block runs its own arbitration and drives the busy flags out, so that companion devices can follow it. In slave role the block ignores its own arbitration, drives its busy outputs low, and gates each port's writes with a busy flag fed in from a master. Several devices can therefore be placed side by side to build a wider word, and all slices commit or drop a colliding write together.

Read data is registered. A read strobed in one cycle returns its word after the next clock edge, together with a valid flag. The data outputs are held at zero whenever no read was strobed. Access to the ports is plain and per cycle: there is no back-pressure and no queueing, so the busy flag is the only feedback a port receives.

Top module: `twin_port_ram`

## Requirements
- R1: Either port may read or write any word independently. A read with `*_en`=1 and `*_oe`=1 returns `mem[addr]` on `*_rdata` with `*_rvalid`=1 in the cycle after the clock edge that samples it.
- R2: A collision exists only when `l_en`=1, `r_en`=1 and `l_addr`==`r_addr`. Without a collision, both busy outputs are 0.
- R3: When a collision starts with neither port carried over from the previous cycle, the left port wins: `busy_r_o`=1 and `busy_l_o`=0. In master role, at most one busy output is ever high.
- R4: A port is carried over when it was enabled in the previous cycle and its address is unchanged. A carried-over port beats a newly arriving one. If both are carried over, the previous cycle's winner stays the winner.
- R5: With `master_mode`=1 the busy outputs report the arbitration and `busy_l_i`/`busy_r_i` have no effect. With `master_mode`=0 both busy outputs are 0.
- R6: With `master_mode`=0 a port's write commits at a clock edge only if that port's busy input is 0 at that edge. Otherwise the word is unchanged.
- R7: With `master_mode`=1 a write from the port whose busy output is 1 is discarded and the word keeps its previous value.
- R8: When a port does not have both `*_en`=1 and `*_oe`=1, its `*_rdata` is 0 and its `*_rvalid` is 0 in the following cycle.
- R9: If one port writes a word in the same cycle that the other port reads it, the read returns the old value. The new value is read back from the next cycle on.
- R10: During and after reset, `*_rdata`=0 and `*_rvalid`=0, and the ownership history is cleared. The word array itself is not cleared. By default it holds 4096 words of 16 bits with 12-bit addresses; setting ADDR_W to 13 gives 8192 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | Role strap: 1 = master, 0 = slave |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left write strobe |
| l_oe | input | 1 | Left read strobe |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, zero when no read |
| l_rvalid | output | 1 | Left read data valid |
| busy_l_i | input | 1 | Busy towards left, used in slave role |
| busy_l_o | output | 1 | Busy towards left, driven in master role |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right write strobe |
| r_oe | input | 1 | Right read strobe |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, zero when no read |
| r_rvalid | output | 1 | Right read data valid |
| busy_r_i | input | 1 | Busy towards right, used in slave role |
| busy_r_o | output | 1 | Busy towards right, driven in master role |

## Verification
The collision logic is tried with five patterns, and each separates a different mistake:
- Writes to distinct words show whether the ports are truly independent.
- Equal addresses with one port disabled show whether the enable takes part in the match.
- A collision in which both ports arrive in the same cycle exposes a wrong default winner.
- A staggered arrival, with the address then moved away and back, shows whether ownership follows history rather than a fixed priority.
- Repeating the colliding writes in slave role, with the busy inputs toggled, shows which busy source gates the write in each role.

A write to a word in the same cycle as a read of that word tells old-data return apart from write-through.

// File: rtl/twin_pkg.sv
package twin_pkg;
  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } role_e;

  localparam int unsigned NPORT = 2;
  localparam int unsigned PL    = 0;
  localparam int unsigned PR    = 1;
endpackage

// File: rtl/twin_arbiter.sv
module twin_arbiter #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_l,
  input  logic              en_r,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  output logic              lose_l,
  output logic              lose_r
);
  logic              seen_l, seen_r, won_r;
  logic [ADDR_W-1:0] last_l, last_r;
  logic              hit, stay_l, stay_r, right_wins;

  always_comb begin
    hit        = en_l && en_r && (addr_l == addr_r);
    stay_l     = seen_l && en_l && (addr_l == last_l);
    stay_r     = seen_r && en_r && (addr_r == last_r);
    right_wins = hit && stay_r && (!stay_l || won_r);
    lose_l     = right_wins;
    lose_r     = hit && !right_wins;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_l <= 1'b0;
      seen_r <= 1'b0;
      won_r  <= 1'b0;
      last_l <= '0;
      last_r <= '0;
    end else begin
      seen_l <= en_l;
      seen_r <= en_r;
      last_l <= addr_l;
      last_r <= addr_r;
      won_r  <= right_wins;
    end
  end
endmodule

// File: rtl/twin_store.sv
module twin_store #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        wr,
  input  logic [1:0]        rd,
  input  logic [ADDR_W-1:0] addr [2],
  input  logic [DATA_W-1:0] wdata [2],
  output logic [DATA_W-1:0] q [2],
  output logic [1:0]        qv
);
  import twin_pkg::*;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // right first so the left write lands last when both hit one word in slave role
  always_ff @(posedge clk) begin
    if (wr[PR]) cells[addr[PR]] <= wdata[PR];
    if (wr[PL]) cells[addr[PL]] <= wdata[PL];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q[p]  <= '0;
        qv[p] <= 1'b0;
      end else if (rd[p]) begin
        q[p]  <= cells[addr[p]];
        qv[p] <= 1'b1;
      end else begin
        q[p]  <= '0;
        qv[p] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/twin_gate.sv
module twin_gate (
  input  logic            role_master,
  input  logic            lose,
  input  logic            busy_in,
  input  logic            en,
  input  logic            we,
  input  logic            oe,
  output logic            busy_out,
  output logic            wr,
  output logic            rd
);
  logic busy_eff;
  always_comb begin
    busy_eff = role_master ? lose : busy_in;
    busy_out = role_master & lose;
    wr       = en & we & ~busy_eff;
    rd       = en & oe;
  end
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_en,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  input  logic              busy_l_i,
  output logic              busy_l_o,
  input  logic              r_en,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid,
  input  logic              busy_r_i,
  output logic              busy_r_o
);
  import twin_pkg::*;

  role_e             role;
  logic              lose_l, lose_r;
  logic [1:0]        wr, rd, qv;
  logic [ADDR_W-1:0] addr  [2];
  logic [DATA_W-1:0] wdata [2];
  logic [DATA_W-1:0] q     [2];

  assign role        = role_e'(master_mode);
  assign addr[PL]    = l_addr;
  assign addr[PR]    = r_addr;
  assign wdata[PL]   = l_wdata;
  assign wdata[PR]   = r_wdata;

  twin_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .en_l(l_en), .en_r(r_en),
    .addr_l(l_addr), .addr_r(r_addr), .lose_l(lose_l), .lose_r(lose_r)
  );

  twin_gate u_gate_l (
    .role_master(role == ROLE_MASTER), .lose(lose_l), .busy_in(busy_l_i),
    .en(l_en), .we(l_we), .oe(l_oe), .busy_out(busy_l_o), .wr(wr[PL]), .rd(rd[PL])
  );

  twin_gate u_gate_r (
    .role_master(role == ROLE_MASTER), .lose(lose_r), .busy_in(busy_r_i),
    .en(r_en), .we(r_we), .oe(r_oe), .busy_out(busy_r_o), .wr(wr[PR]), .rd(rd[PR])
  );

  twin_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .q(q), .qv(qv)
  );

  assign l_rdata  = q[PL];
  assign r_rdata  = q[PR];
  assign l_rvalid = qv[PL];
  assign r_rvalid = qv[PR];
endmodule

// File: rtl/twin_port_ram_chk.sv
module twin_port_ram_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_mode,
  input logic              l_en,
  input logic              l_we,
  input logic              l_oe,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_wdata,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_rvalid,
  input logic              busy_l_i,
  input logic              busy_l_o,
  input logic              r_en,
  input logic              r_we,
  input logic              r_oe,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_wdata,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_rvalid,
  input logic              busy_r_i,
  input logic              busy_r_o
);
  p_busy_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_l_o || busy_r_o) |-> (l_en && r_en && l_addr == r_addr));

  p_one_loser_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_l_o && busy_r_o));

  p_hold_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && $past(master_mode) && $past(rst_n) && $past(busy_r_o)
     && $stable(l_addr) && $stable(r_addr) && l_en && r_en) |-> busy_r_o);

  p_slave_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (!busy_l_o && !busy_r_o));

  p_read_gate_l_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_en && l_oe) |=> (l_rdata == '0 && !l_rvalid));

  p_read_gate_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_en && r_oe) |=> (r_rdata == '0 && !r_rvalid));
endmodule

bind twin_port_ram twin_port_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/twin_port_ram_tb.sv
`timescale 1ns/1ps
module twin_port_ram_tb;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic l_en = 0, l_we = 0, l_oe = 0, r_en = 0, r_we = 0, r_oe = 0;
  logic busy_l_i = 0, busy_r_i = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_rvalid, r_rvalid, busy_l_o, busy_r_o;

  always #2.5 clk = ~clk;

  twin_port_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

  // staged stimulus applied at the next negedge
  logic s_mode = 1, s_len = 0, s_lwe = 0, s_loe = 0, s_ren = 0, s_rwe = 0, s_roe = 0;
  logic s_bil = 0, s_bir = 0;
  int   s_la = 0, s_ra = 0, s_ld = 0, s_rd = 0;

  // reference model state
  int   mem [int];
  bit   pl_en = 0, pr_en = 0, p_rwin = 0;
  int   pl_a = 0, pr_a = 0;

  int checks = 0, fails = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setl(input bit en, input bit we, input bit oe, input int a, input int d);
    s_len = en; s_lwe = we; s_loe = oe; s_la = a; s_ld = d;
  endtask
  task automatic setr(input bit en, input bit we, input bit oe, input int a, input int d);
    s_ren = en; s_rwe = we; s_roe = oe; s_ra = a; s_rd = d;
  endtask
  task automatic idle();
    setl(0, 0, 0, 0, 0); setr(0, 0, 0, 0, 0);
  endtask

  // one clock cycle: drive, check busy, clock, check read data, update model
  task automatic step(input string tag);
    bit hit, stl, str, rwin, ebl, ebr, effl, effr, wl, wr;
    bit rl, rr, kl, kr;
    int el, er;
    @(negedge clk);
    master_mode = s_mode; busy_l_i = s_bil; busy_r_i = s_bir;
    l_en = s_len; l_we = s_lwe; l_oe = s_loe; l_addr = AW'(s_la); l_wdata = DW'(s_ld);
    r_en = s_ren; r_we = s_rwe; r_oe = s_roe; r_addr = AW'(s_ra); r_wdata = DW'(s_rd);
    #1;
    hit  = s_len && s_ren && (s_la == s_ra);
    stl  = pl_en && s_len && (s_la == pl_a);
    str  = pr_en && s_ren && (s_ra == pr_a);
    rwin = 0;
    if (hit) begin
      if (str && !stl) rwin = 1;
      else if (str && stl) rwin = p_rwin;
    end
    ebl = s_mode && hit && rwin;
    ebr = s_mode && hit && !rwin;
    chk({tag, " busy_l"}, busy_l_o, ebl);
    chk({tag, " busy_r"}, busy_r_o, ebr);
    effl = s_mode ? ebl : s_bil;
    effr = s_mode ? ebr : s_bir;
    wl = s_len && s_lwe && !effl;
    wr = s_ren && s_rwe && !effr;
    rl = s_len && s_loe; rr = s_ren && s_roe;
    kl = rl && mem.exists(s_la); kr = rr && mem.exists(s_ra);
    el = kl ? mem[s_la] : 0;
    er = kr ? mem[s_ra] : 0;
    @(posedge clk); #1;
    chk({tag, " l_rvalid"}, l_rvalid, rl);
    chk({tag, " r_rvalid"}, r_rvalid, rr);
    if (!rl || kl) chk({tag, " l_rdata"}, l_rdata, el);
    if (!rr || kr) chk({tag, " r_rdata"}, r_rdata, er);
    if (wr) mem[s_ra] = s_rd;
    if (wl) mem[s_la] = s_ld;
    pl_en = s_len; pr_en = s_ren; pl_a = s_la; pr_a = s_ra; p_rwin = rwin;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R10 rdata reset", l_rdata | r_rdata, 0);
    chk("R10 rvalid reset", l_rvalid | r_rvalid, 0);
    chk("R10 busy reset", busy_l_o | busy_r_o, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(); step("R10 idle");

    // R1: independent writes and cross reads
    setl(1, 1, 0, 5, 'h1111); setr(1, 1, 0, 9, 'h2222); step("R1 write");
    setl(1, 0, 1, 9, 0);      setr(1, 0, 1, 5, 0);      step("R1 read");
    setl(1, 1, 1, 7, 'h0001); setr(0, 0, 0, 0, 0);      step("R1 seed");
    idle(); step("R1 gap");

    // R9: write and read of one word in one cycle
    setl(1, 1, 0, 7, 'hAAAA); setr(1, 0, 1, 7, 0); step("R9 old");
    idle(); step("R9 gap");
    setr(1, 0, 1, 7, 0); step("R9 new");
    idle(); step("R9 gap2");

    // R2: equal address but one port disabled, and distinct addresses
    setl(1, 0, 1, 20, 0); setr(0, 1, 0, 20, 'h9999); step("R2 disabled");
    setr(1, 0, 1, 21, 0); step("R2 distinct");
    idle(); step("R2 gap");

    // R3 and R7: simultaneous start, left wins, right write dropped
    setl(1, 1, 0, 30, 'h3333); setr(1, 1, 0, 30, 'h4444); step("R3 tie");
    step("R3 held");
    idle(); step("R7 gap");
    setl(1, 0, 1, 30, 0); step("R7 readback");
    idle(); step("R7 gap2");

    // R4: right arrives first and keeps ownership
    setl(1, 1, 0, 40, 'h4040); step("R4 seed");
    idle(); step("R4 gap");
    setr(1, 0, 1, 40, 0); step("R4 right first");
    setl(1, 1, 0, 40, 'h5555); step("R4 left late");
    step("R4 both stay");
    setr(1, 0, 1, 41, 0); step("R4 right moves");
    setr(1, 0, 1, 40, 0); step("R4 right returns");
    idle(); step("R4 gap2");
    setl(1, 0, 1, 40, 0); step("R4 readback");

    // R8: read needs both enable and read strobe
    setl(1, 0, 0, 40, 0); step("R8 no oe");
    setl(0, 0, 1, 40, 0); step("R8 no en");

    // R5: busy inputs ignored in master role
    idle(); s_bil = 1; s_bir = 1;
    setl(1, 1, 0, 50, 'h0550); step("R5 master ignores busy_i");
    s_bil = 0; s_bir = 0; idle(); step("R5 gap");
    setl(1, 0, 1, 50, 0); step("R5 readback");

    // R6 and R5: slave role gated by busy inputs, outputs quiet
    s_mode = 0; s_bil = 1; s_bir = 0;
    setl(1, 1, 0, 60, 'h6666); setr(1, 1, 0, 61, 'h6161); step("R6 slave busy");
    s_bil = 0; s_bir = 1; setl(1, 1, 0, 61, 'h7777); setr(1, 1, 0, 61, 'h8888); step("R5 slave collide");
    s_bir = 0; idle(); step("R6 gap");
    setl(1, 0, 1, 60, 0); setr(1, 0, 1, 61, 0); step("R6 readback");
    s_bil = 0; setl(1, 1, 0, 60, 'h6060); step("R6 commit");
    setl(1, 0, 1, 60, 0); step("R6 readback2");
    idle(); step("end");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule